// File: doc/BRIEF.md
# PWM Event-Action Waveform Generator

This block produces one pulse-width-modulated output from a free-running counter. A counter of parameterized width either falls from a programmed top value to zero and reloads, or rises from zero to the top value and falls back again. Each cycle the counter value is compared against the top value, against zero and against two compare thresholds. Every match produces an event, and compare matches are tagged with the direction the counter is moving. Each event owns a 2-bit action taken from a 12-bit action word. The action can leave the output alone, invert it, or force it low or high.

The action word is double-buffered. A write port fills a pending copy. The pending copy moves to the active copy only on a cycle where the counter is at zero. In immediate mode the first such zero is used. In synchronized mode the transfer waits for a zero that follows a one-cycle sync request pulse. When several events fire in the same cycle, a fixed priority picks which single action is applied. The raw event strobes are also brought out for neighbouring logic.

Top module: `pwm_action_gen`

## Requirements
- R1: After reset the output is low, the counter is at zero and the active action word is all zeros, so the output stays low until a new word becomes active. With `cnt_en` low, all event strobes are zero and the counter holds.
- R2: With `mode_updown`=0 the counter steps down by one each enabled cycle and reloads `load_val` on the cycle after it reads zero, giving a period of `load_val`+1 cycles.
- R3: With `mode_updown`=1 the counter rises by one from zero to `load_val`, then falls by one back to zero, giving a period of 2·`load_val` cycles.
- R4: Event strobe bits are: 0 = counter equals zero, 1 = counter equals `load_val`, 2 = equals `cmp_a` while rising, 3 = equals `cmp_a` while falling, 4 = equals `cmp_b` while rising, 5 = equals `cmp_b` while falling. A cycle at zero counts as falling and a cycle at `load_val` counts as rising. In count-down mode bits 2 and 4 never fire.
- R5: When several events fire together, exactly one action is applied, by priority: zero, then load, then compare A, then compare B.
- R6: The action for event bit k sits in active word bits [2k+1:2k]. The codes are 00 = keep, 01 = invert, 10 = force low, 11 = force high. The output register takes the result on the clock edge that ends the event cycle. With no event the output holds.
- R7: With `sync_mode`=0, a written word becomes active on the edge that ends the next cycle where the counter reads zero. The action applied in that zero cycle still comes from the old word.
- R8: With `sync_mode`=1, a pending word is transferred only at a zero cycle that comes after a `sync_req` pulse. The pulse is remembered until the next zero cycle consumes it, whether or not a word is pending.
- R9: A write that arrives while a word is pending replaces it, and the earlier word is never applied. A write in the same cycle as a transfer zero cancels that transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_en | input | 1 | Counter run enable; gates all events |
| mode_updown | input | 1 | 0 = count down with reload, 1 = count up then down |
| load_val | input | CNT_W | Counter top value |
| cmp_a | input | CNT_W | Compare A threshold |
| cmp_b | input | CNT_W | Compare B threshold |
| act_wr | input | 1 | Write strobe for the pending action word |
| act_wdata | input | 12 | Action word to write |
| sync_mode | input | 1 | 0 = transfer at next zero, 1 = transfer only after a sync request |
| sync_req | input | 1 | One-cycle synchronized-transfer request |
| pwm_out | output | 1 | PWM output |
| evt | output | 6 | Event strobes, bit layout per R4 |

## Verification
The hardest cases to reach are the coincidences: compare A equal to compare B, a compare equal to zero or to the top value, and a top value of 1 where zero and load alternate every cycle. The bench sweeps both compare thresholds over every value from 0 to the top value, for two top values and both counting modes. For each combination it writes a fresh pseudo-random action word, so all four action codes meet every tie-break. Separate phases then hold a word pending across several zeros without a sync request, and rewrite a pending word before its zero arrives.

// File: rtl/pwm_gen_pkg.sv
package pwm_gen_pkg;
   localparam int NUM_EV  = 6;
   localparam int ACT_W   = 2;
   localparam int WORD_W  = NUM_EV * ACT_W;
   // event index doubles as priority: lower index wins
   localparam int EV_ZERO = 0;
   localparam int EV_LOAD = 1;
   localparam int EV_AU   = 2;
   localparam int EV_AD   = 3;
   localparam int EV_BU   = 4;
   localparam int EV_BD   = 5;

   typedef enum logic [ACT_W-1:0] {
      ACT_KEEP = 2'b00,
      ACT_FLIP = 2'b01,
      ACT_LOW  = 2'b10,
      ACT_HIGH = 2'b11
   } act_e;
endpackage

// File: rtl/pwm_cnt.sv
module pwm_cnt #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             updown,
   input  logic [CNT_W-1:0] load_val,
   output logic [CNT_W-1:0] cnt,
   output logic             dir_up
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   generate
      if (CNT_W < 2) begin : g_bad_width
         $error("pwm_cnt: CNT_W must be at least 2");
      end
   endgenerate

   logic up_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt  <= '0;
         up_q <= 1'b0;
      end else if (en) begin
         if (!updown) begin
            up_q <= 1'b0;
            cnt  <= (cnt == '0) ? load_val : cnt - ONE;
         end else if (up_q) begin
            if (cnt >= load_val) begin
               up_q <= 1'b0;
               cnt  <= (cnt == '0) ? '0 : cnt - ONE;
            end else begin
               cnt  <= cnt + ONE;
            end
         end else begin
            if (cnt == '0) begin
               up_q <= (load_val != '0);
               cnt  <= (load_val == '0) ? '0 : ONE;
            end else begin
               cnt  <= cnt - ONE;
            end
         end
      end
   end

   assign dir_up = updown & up_q;

   // R2: count-down reload after zero
   p_down_reload_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !updown && cnt == '0) |=> (cnt == $past(load_val)));

   // R3: up/down mode always moves by exactly one
   p_updown_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (en && updown && load_val != '0) |=>
         ((cnt == CNT_W'($past(cnt) + ONE)) || (cnt == CNT_W'($past(cnt) - ONE))));
endmodule

// File: rtl/pwm_evt.sv
module pwm_evt
   import pwm_gen_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic              en,
   input  logic [CNT_W-1:0]  cnt,
   input  logic              dir_up,
   input  logic [CNT_W-1:0]  load_val,
   input  logic [CNT_W-1:0]  cmp_a,
   input  logic [CNT_W-1:0]  cmp_b,
   output logic [NUM_EV-1:0] ev
);
   localparam int NUM_CMP = 2;

   logic [NUM_CMP-1:0][CNT_W-1:0] thr;
   assign thr = {cmp_b, cmp_a};

   assign ev[EV_ZERO] = en && (cnt == '0);
   assign ev[EV_LOAD] = en && (cnt == load_val);

   generate
      for (genvar k = 0; k < NUM_CMP; k++) begin : g_cmp
         logic hit;
         assign hit                = en && (cnt == thr[k]);
         assign ev[EV_AU + 2*k]    = hit &  dir_up;
         assign ev[EV_AD + 2*k]    = hit & ~dir_up;
      end
   endgenerate
endmodule

// File: rtl/pwm_act_reg.sv
module pwm_act_reg
   import pwm_gen_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [WORD_W-1:0] wdata,
   input  logic              sync_mode,
   input  logic              sync_req,
   input  logic              zero,
   output logic [WORD_W-1:0] active
);
   logic [WORD_W-1:0] pending;
   logic              pend_v;
   logic              armed;
   logic              commit;

   assign commit = zero && pend_v && !wr && (!sync_mode || armed);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pending <= '0;
         pend_v  <= 1'b0;
         armed   <= 1'b0;
         active  <= '0;
      end else begin
         armed <= sync_req | (armed & ~zero);
         if (wr) begin
            pending <= wdata;
            pend_v  <= 1'b1;
         end else if (commit) begin
            pend_v  <= 1'b0;
         end
         if (commit) active <= pending;
      end
   end

   // R7: immediate mode transfers at zero
   p_imm_commit_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (zero && pend_v && !wr && !sync_mode) |=> (active == $past(pending)));

   // R8: synchronized mode holds without a request
   p_sync_wait_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_mode && !armed) |=> $stable(active));

   // R9: a write never coincides with a transfer
   p_write_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
      wr |=> $stable(active));
endmodule

// File: rtl/pwm_out_ctl.sv
module pwm_out_ctl
   import pwm_gen_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_EV-1:0] ev,
   input  logic [WORD_W-1:0] active,
   output logic              pwm
);
   act_e sel;
   logic nxt;

   always_comb begin
      sel = ACT_KEEP;
      for (int i = NUM_EV - 1; i >= 0; i--) begin
         if (ev[i]) sel = act_e'(active[i*ACT_W +: ACT_W]);
      end
   end

   always_comb begin
      unique case (sel)
         ACT_FLIP: nxt = ~pwm;
         ACT_LOW:  nxt = 1'b0;
         ACT_HIGH: nxt = 1'b1;
         default:  nxt = pwm;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) pwm <= 1'b0;
      else        pwm <= nxt;
   end

   // R6: no event, no change
   p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ev == '0) |=> $stable(pwm));

   // R5: zero event dominates everything else
   p_zero_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ev[EV_ZERO] && active[1:0] == 2'b11) |=> pwm);
endmodule

// File: rtl/pwm_action_gen.sv
module pwm_action_gen
   import pwm_gen_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cnt_en,
   input  logic              mode_updown,
   input  logic [CNT_W-1:0]  load_val,
   input  logic [CNT_W-1:0]  cmp_a,
   input  logic [CNT_W-1:0]  cmp_b,
   input  logic              act_wr,
   input  logic [11:0]       act_wdata,
   input  logic              sync_mode,
   input  logic              sync_req,
   output logic              pwm_out,
   output logic [5:0]        evt
);
   generate
      if (WORD_W != 12) begin : g_bad_word
         $error("pwm_action_gen: action word must be 12 bits");
      end
   endgenerate

   logic [CNT_W-1:0]  cnt;
   logic              dir_up;
   logic [NUM_EV-1:0] ev;
   logic [WORD_W-1:0] active;

   pwm_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .en(cnt_en), .updown(mode_updown),
      .load_val(load_val), .cnt(cnt), .dir_up(dir_up)
   );

   pwm_evt #(.CNT_W(CNT_W)) u_evt (
      .en(cnt_en), .cnt(cnt), .dir_up(dir_up), .load_val(load_val),
      .cmp_a(cmp_a), .cmp_b(cmp_b), .ev(ev)
   );

   pwm_act_reg u_act (
      .clk(clk), .rst_n(rst_n), .wr(act_wr), .wdata(act_wdata),
      .sync_mode(sync_mode), .sync_req(sync_req), .zero(ev[EV_ZERO]),
      .active(active)
   );

   pwm_out_ctl u_out (
      .clk(clk), .rst_n(rst_n), .ev(ev), .active(active), .pwm(pwm_out)
   );

   assign evt = ev;

   // R4: rising-tagged compares never appear when counting down only
   p_no_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_updown |-> (!evt[EV_AU] && !evt[EV_BU]));

   // R1: halted counter raises no events
   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !cnt_en |-> (evt == '0));
endmodule

// File: tb/tb_pwm_action_gen.sv
module tb_pwm_action_gen;
   localparam int CLK_PERIOD = 10;
   localparam int W = 16;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          cnt_en, mode_updown, act_wr, sync_mode, sync_req;
   logic [W-1:0]  load_val, cmp_a, cmp_b;
   logic [11:0]   act_wdata;
   logic          pwm_out;
   logic [5:0]    evt;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 0;

   // reference state
   int        m_cnt;
   bit        m_up, m_pwm, m_pv, m_arm;
   bit [11:0] m_act, m_pend;
   logic [31:0] seed = 32'h1234_5678;

   always #(CLK_PERIOD/2) clk = ~clk;

   pwm_action_gen #(.CNT_W(W)) dut (
      .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .mode_updown(mode_updown),
      .load_val(load_val), .cmp_a(cmp_a), .cmp_b(cmp_b), .act_wr(act_wr),
      .act_wdata(act_wdata), .sync_mode(sync_mode), .sync_req(sync_req),
      .pwm_out(pwm_out), .evt(evt)
   );

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   // one clock: inputs already set by caller; check events, advance model, check output
   task automatic cyc(input string tag_ev, input string tag_out);
      bit [5:0] e;
      bit [1:0] a;
      bit       z, dir, commit;
      #1;
      dir = mode_updown && m_up;
      z   = cnt_en && (m_cnt == 0);
      e   = '0;
      e[0] = z;
      e[1] = cnt_en && (m_cnt == int'(load_val));
      e[2] = cnt_en && (m_cnt == int'(cmp_a)) &&  dir;
      e[3] = cnt_en && (m_cnt == int'(cmp_a)) && !dir;
      e[4] = cnt_en && (m_cnt == int'(cmp_b)) &&  dir;
      e[5] = cnt_en && (m_cnt == int'(cmp_b)) && !dir;
      chk(tag_ev, int'(evt), int'(e));
      a = 2'b00;
      for (int i = 0; i < 6; i++) begin
         if (e[i]) begin
            a = m_act[2*i +: 2];
            break;
         end
      end
      case (a)
         2'b01: m_pwm = !m_pwm;
         2'b10: m_pwm = 1'b0;
         2'b11: m_pwm = 1'b1;
         default: ;
      endcase
      commit = z && m_pv && !act_wr && (!sync_mode || m_arm);
      if (commit) m_act = m_pend;
      m_arm = sync_req || (m_arm && !z);
      if (act_wr) begin
         m_pend = act_wdata;
         m_pv   = 1'b1;
      end else if (commit) m_pv = 1'b0;
      if (cnt_en) begin
         if (!mode_updown) begin
            m_up  = 0;
            m_cnt = (m_cnt == 0) ? int'(load_val) : m_cnt - 1;
         end else if (m_up) begin
            if (m_cnt >= int'(load_val)) begin
               m_up  = 0;
               m_cnt = (m_cnt == 0) ? 0 : m_cnt - 1;
            end else m_cnt = m_cnt + 1;
         end else if (m_cnt == 0) begin
            m_up  = (load_val != 0);
            m_cnt = (load_val == 0) ? 0 : 1;
         end else m_cnt = m_cnt - 1;
      end
      @(posedge clk);
      #1;
      chk(tag_out, int'(pwm_out), int'(m_pwm));
      act_wr   = 1'b0;
      sync_req = 1'b0;
   endtask

   function automatic logic [11:0] next_word();
      seed = seed * 32'd1103515245 + 32'd12345;
      return seed[27:16];
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      rst_n = 0; cnt_en = 0; mode_updown = 0; act_wr = 0; sync_mode = 0;
      sync_req = 0; load_val = 4; cmp_a = 1; cmp_b = 2; act_wdata = '0;
      m_cnt = 0; m_up = 0; m_pwm = 0; m_pv = 0; m_arm = 0; m_act = 0; m_pend = 0;
      repeat (3) @(posedge clk);
      #1;
      rst_n = 1;
      // R1: reset state
      chk("R1 pwm after reset", int'(pwm_out), 0);
      for (int i = 0; i < 4; i++) cyc("R1 idle events", "R1 idle output");
      cnt_en = 1;
      for (int i = 0; i < 12; i++) cyc("R1 events", "R1 zero word keeps low");

      // sweep: modes, top values, both thresholds over 0..top
      for (int md = 0; md < 2; md++) begin
         for (int li = 0; li < 2; li++) begin
            for (int ca = 0; ca <= 4; ca++) begin
               for (int cb = 0; cb <= 4; cb++) begin
                  if (li == 0 && (ca > 1 || cb > 1)) continue;
                  mode_updown = md[0];
                  load_val    = (li == 0) ? 1 : 4;
                  cmp_a       = W'(ca);
                  cmp_b       = W'(cb);
                  act_wr      = 1;
                  act_wdata   = next_word();
                  for (int c = 0; c < 20; c++)
                     cyc(md ? "R3/R4 updown events" : "R2/R4 down events",
                         "R5/R6/R7 output");
               end
            end
         end
      end

      // R8: synchronized transfer
      sync_mode = 1; mode_updown = 0; load_val = 3; cmp_a = 1; cmp_b = 2;
      act_wr = 1; act_wdata = 12'h003;
      for (int c = 0; c < 14; c++) cyc("R8 events", "R8 held without request");
      sync_req = 1;
      for (int c = 0; c < 10; c++) cyc("R8 events", "R8 after request");
      sync_req = 1;
      for (int c = 0; c < 6; c++) cyc("R8 events", "R8 request consumed");
      act_wr = 1; act_wdata = 12'h002;
      for (int c = 0; c < 10; c++) cyc("R8 events", "R8 stale request unused");

      // R9: overwrite while pending
      sync_mode = 0; mode_updown = 1; load_val = 4;
      for (int c = 0; c < 3; c++) cyc("R9 events", "R9 output");
      act_wr = 1; act_wdata = 12'h003;
      cyc("R9 events", "R9 output");
      act_wr = 1; act_wdata = 12'h001;
      for (int c = 0; c < 20; c++) cyc("R9 events", "R9 first word discarded");
      // R9: write landing exactly on a zero cycle cancels that transfer
      for (int c = 0; c < 20; c++) begin
         if (m_cnt == 0 && c > 0) begin
            act_wr = 1; act_wdata = 12'h00E;
         end
         cyc("R9 events", "R9 write at zero");
      end

      // R1: halted counter holds
      cnt_en = 0;
      for (int c = 0; c < 5; c++) cyc("R1 halted events", "R1 halted output");
      cnt_en = 1;
      for (int c = 0; c < 10; c++) cyc("R3 resume events", "R6 resume output");

      summary();
   end
endmodule